// File: doc/BRIEF.md
# Transition-Triggered Power Sequencer

This controller sits in front of a memory-and-logic array. It keeps a registered copy of a bus of address and logic inputs. When any bit of that bus differs from its value one clock earlier, it enables the array for a programmable number of clock cycles. It then strobes an output register that captures the array's result and returns to standby by itself. While the block is in standby, the captured value stays on the outputs. The array therefore draws power only in a short window after each input change, and the data presented downstream stays valid while it sleeps.

A chip-select input is not needed for power saving, but it overrides everything. Deasserting it removes array enable and strobe in the same cycle and parks the state machine in standby. Input changes while it is low start nothing. When chip-select returns, a fresh window refreshes the outputs for whatever inputs are present. A saturating counter of started windows lets a test confirm that steady inputs cause no activity.

The state machine has three states. IDLE is standby. EVAL means the array is enabled and the window counter runs. LATCH means the array is enabled and the capture strobe fires. The transitions are:
- IDLE to EVAL: on an input change or a chip-select rising edge. This is a window start.
- EVAL to EVAL: on a new change, which restarts the window, or while the count is below its last value.
- EVAL to LATCH: when the count reaches its last value.
- LATCH to IDLE: when no change is seen.
- LATCH to EVAL: on a change, which restarts the window.
- Any state to IDLE: when chip-select is low.

Top module: `psq_sequencer`

## Requirements
- R1: A change on `mon_i` is registered at the next clock edge and sets `arr_en_o` after the edge that follows. The bench sees it at the second falling edge after driving.
- R2: After `WIN_CYC` enabled EVAL cycles, `latch_stb_o` is high for exactly one cycle, at the (WIN_CYC+2)-th falling edge after the input change. At the next edge `data_q_o` takes the value of `arr_data_i` sampled in the strobe cycle.
- R3: After a strobe with no new change, the block returns to standby (`standby_o`=1, `arr_en_o`=0) in the next cycle without any chip-select activity.
- R4: While `mon_i` is steady, the block stays in standby, `data_q_o` keeps its value and no window starts.
- R5: While `chip_sel_i` is low, `arr_en_o` and `latch_stb_o` are 0 and `standby_o` is 1 in that same cycle. Input changes start no window and leave `data_q_o` unchanged.
- R6: From the cycle in which a trigger is seen to the strobe cycle, the latency never exceeds `BUDGET_CYC` cycles.
- R7: A change during EVAL or LATCH restarts the window. Only one strobe follows, and it captures the data for the newest inputs, `WIN_CYC+2` falling edges after that last change.
- R8: A rising edge of `chip_sel_i` starts a window. `arr_en_o` is high at the first falling edge after the rise, and the strobe comes at the (WIN_CYC+1)-th falling edge.
- R9: After reset, `standby_o`=1, `arr_en_o`=0, `latch_stb_o`=0, `data_q_o`=0 and `wake_cnt_o`=0.
- R10: `wake_cnt_o` rises by one on each IDLE-to-EVAL start. A restart does not count. The counter saturates at 2^CNT_W-1 and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_sel_i | input | 1 | Chip select, high = enabled; low forces standby |
| mon_i | input | IN_W | Monitored address and logic inputs |
| arr_data_i | input | DATA_W | Output data of the array |
| arr_en_o | output | 1 | Array enable (wake window active) |
| latch_stb_o | output | 1 | One-cycle capture strobe |
| standby_o | output | 1 | High while the block is in standby |
| data_q_o | output | DATA_W | Latched array data |
| wake_cnt_o | output | CNT_W | Saturating count of started windows |

## Verification
The hardest situations to reach are a window interrupted part-way, first by a newer input change and then by chip-select falling. Either one must leave exactly one later capture, or none, with the right data. The stimulus drives a second input value while the array is already enabled and counts falling edges from that second change to the strobe. In a separate sequence it drops chip-select mid-window, toggles the inputs while deselected and then re-selects. The scoreboard holds one expected value per capture, so a lost, extra or stale capture shows up as a mismatch.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        PSQ_IDLE  = 2'd0,
        PSQ_EVAL  = 2'd1,
        PSQ_LATCH = 2'd2
    } psq_state_e;

endpackage

// File: rtl/psq_edge_detect.sv
module psq_edge_detect #(
    parameter int IN_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            chip_sel_i,
    input  logic [IN_W-1:0] mon_i,
    output logic            change_o,
    output logic            cs_rise_o
);

    logic [IN_W-1:0] mon_q;
    logic [IN_W-1:0] mon_qq;
    logic            cs_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mon_q  <= '0;
            mon_qq <= '0;
            cs_q   <= 1'b1;
        end else begin
            mon_q  <= mon_i;
            mon_qq <= mon_q;
            cs_q   <= chip_sel_i;
        end
    end

    assign change_o  = |(mon_q ^ mon_qq);
    assign cs_rise_o = chip_sel_i & ~cs_q;

endmodule

// File: rtl/psq_window_fsm.sv
module psq_window_fsm
    import psq_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       chip_sel_i,
    input  logic       change_i,
    input  logic       cs_rise_i,
    output psq_state_e state_o,
    output logic       arr_en_o,
    output logic       latch_stb_o,
    output logic       standby_o,
    output logic       wake_start_o
);

    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);

    psq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PSQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        wake_start_o = 1'b0;
        if (!chip_sel_i) begin
            state_d = PSQ_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PSQ_IDLE: begin
                    if (change_i || cs_rise_i) begin
                        state_d      = PSQ_EVAL;
                        cnt_d        = '0;
                        wake_start_o = 1'b1;
                    end
                end
                PSQ_EVAL: begin
                    if (change_i) begin
                        cnt_d = '0;
                    end else if (cnt_q == WIN_LAST) begin
                        state_d = PSQ_LATCH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PSQ_LATCH: begin
                    cnt_d   = '0;
                    state_d = change_i ? PSQ_EVAL : PSQ_IDLE;
                end
                default: begin
                    state_d = PSQ_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        arr_en_o    = 1'b0;
        latch_stb_o = 1'b0;
        unique case (state_q)
            PSQ_IDLE:  arr_en_o = 1'b0;
            PSQ_EVAL:  arr_en_o = chip_sel_i;
            PSQ_LATCH: begin
                arr_en_o    = chip_sel_i;
                latch_stb_o = chip_sel_i & ~change_i;
            end
            default:   arr_en_o = 1'b0;
        endcase
        standby_o = ~arr_en_o;
    end

    assign state_o = state_q;

endmodule

// File: rtl/psq_out_latch.sv
module psq_out_latch #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic              wake_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] data_q_o,
    output logic [CNT_W-1:0]  wake_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q_o <= '0;
        end else if (capture_i) begin
            data_q_o <= arr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wake_cnt_o <= '0;
        end else if (wake_i && (wake_cnt_o != CNT_MAX)) begin
            wake_cnt_o <= wake_cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer
    import psq_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int DATA_W     = 8,
    parameter int WIN_CYC    = 4,
    parameter int BUDGET_CYC = 8,
    parameter int CNT_W      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              chip_sel_i,
    input  logic [IN_W-1:0]   mon_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic              arr_en_o,
    output logic              latch_stb_o,
    output logic              standby_o,
    output logic [DATA_W-1:0] data_q_o,
    output logic [CNT_W-1:0]  wake_cnt_o
);

    logic       mon_change;
    logic       cs_rise;
    logic       wake_start;
    psq_state_e fsm_state;

    psq_edge_detect #(.IN_W(IN_W)) u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .chip_sel_i (chip_sel_i),
        .mon_i      (mon_i),
        .change_o   (mon_change),
        .cs_rise_o  (cs_rise)
    );

    psq_window_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .chip_sel_i   (chip_sel_i),
        .change_i     (mon_change),
        .cs_rise_i    (cs_rise),
        .state_o      (fsm_state),
        .arr_en_o     (arr_en_o),
        .latch_stb_o  (latch_stb_o),
        .standby_o    (standby_o),
        .wake_start_o (wake_start)
    );

    psq_out_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_latch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_i  (latch_stb_o),
        .wake_i     (wake_start),
        .arr_data_i (arr_data_i),
        .data_q_o   (data_q_o),
        .wake_cnt_o (wake_cnt_o)
    );

endmodule

// File: rtl/psq_sequencer_chk.sv
module psq_sequencer_chk #(
    parameter int DATA_W     = 8,
    parameter int BUDGET_CYC = 8,
    parameter int CNT_W      = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              chip_sel_i,
    input logic              change_i,
    input logic              cs_rise_i,
    input logic [DATA_W-1:0] arr_data_i,
    input logic              arr_en_o,
    input logic              latch_stb_o,
    input logic              standby_o,
    input logic [DATA_W-1:0] data_q_o,
    input logic [CNT_W-1:0]  wake_cnt_o
);

    localparam int SW = $clog2(BUDGET_CYC + 2) + 1;
    localparam logic [SW-1:0] S_MAX = '1;

    logic [SW-1:0] since_trig;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_trig <= '0;
        end else if (change_i || cs_rise_i) begin
            since_trig <= SW'(1);
        end else if (since_trig != S_MAX) begin
            since_trig <= since_trig + 1'b1;
        end
    end

    assert_wake_on_change_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standby_o && chip_sel_i && change_i) |=> (arr_en_o || !chip_sel_i));

    assert_capture_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_stb_o |=> (data_q_o == $past(arr_data_i)));

    assert_back_to_standby_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_stb_o |=> standby_o);

    assert_hold_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !latch_stb_o |=> $stable(data_q_o));

    assert_cs_override_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chip_sel_i |-> (standby_o && !arr_en_o && !latch_stb_o));

    assert_within_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_stb_o |-> (since_trig <= SW'(BUDGET_CYC)));

    assert_cnt_monotonic_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (wake_cnt_o >= $past(wake_cnt_o)));

endmodule

bind psq_sequencer psq_sequencer_chk #(
    .DATA_W     (DATA_W),
    .BUDGET_CYC (BUDGET_CYC),
    .CNT_W      (CNT_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chip_sel_i  (chip_sel_i),
    .change_i    (mon_change),
    .cs_rise_i   (cs_rise),
    .arr_data_i  (arr_data_i),
    .arr_en_o    (arr_en_o),
    .latch_stb_o (latch_stb_o),
    .standby_o   (standby_o),
    .data_q_o    (data_q_o),
    .wake_cnt_o  (wake_cnt_o)
);

// File: tb/psq_sequencer_tb.sv
module psq_sequencer_tb_top;

    localparam int IN_W    = 16;
    localparam int DATA_W  = 8;
    localparam int WIN     = 4;
    localparam int BUDGET  = 8;
    localparam int CNT_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs = 1'b1;
    logic [IN_W-1:0]   mon = '0;
    logic [DATA_W-1:0] arr_data;
    logic              arr_en, stb, standby;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  wcnt;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] sb_q[$];

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] model(input logic [IN_W-1:0] v);
        return v[7:0] ^ v[15:8] ^ 8'hA5;
    endfunction

    assign arr_data = model(mon);

    psq_sequencer #(
        .IN_W(IN_W), .DATA_W(DATA_W), .WIN_CYC(WIN),
        .BUDGET_CYC(BUDGET), .CNT_W(CNT_W)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .chip_sel_i(cs), .mon_i(mon),
        .arr_data_i(arr_data), .arr_en_o(arr_en), .latch_stb_o(stb),
        .standby_o(standby), .data_q_o(data_q), .wake_cnt_o(wcnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: the cycle after a strobe, compare with the queue head
    bit prev_stb = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_stb) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected capture", int'(data_q), -1);
            end else begin
                logic [DATA_W-1:0] e;
                e = sb_q.pop_front();
                chk(data_q == e, "R2 scoreboard", int'(data_q), int'(e));
            end
        end
        prev_stb = rst_n && stb;
    end

    function automatic void bump_cnt();
        if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
    endfunction

    // Driver: one bus cycle, full window, latency and data checks
    task automatic wake(input logic [IN_W-1:0] v);
        int n = 0;
        int en_at = 0;
        @(negedge clk);
        mon = v;
        sb_q.push_back(model(v));
        bump_cnt();
        while (!stb && n < 40) begin
            @(negedge clk);
            n++;
            if (arr_en && en_at == 0) en_at = n;
        end
        chk(en_at == 2, "R1 enable delay", en_at, 2);
        chk(n == WIN + 2, "R6 strobe latency", n, WIN + 2);
        @(negedge clk);
        chk(standby && !arr_en, "R3 standby after capture", int'(standby), 1);
        chk(data_q == model(v), "R2 captured data", int'(data_q), int'(model(v)));
        chk(int'(wcnt) == exp_cnt, "R10 window count", int'(wcnt), exp_cnt);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] held;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(standby && !arr_en && !stb, "R9 reset standby", int'(standby), 1);
        chk(data_q == '0, "R9 reset data", int'(data_q), 0);
        chk(wcnt == '0, "R9 reset count", int'(wcnt), 0);

        // R4 steady inputs: no activity
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!standby || arr_en) chk(1'b0, "R4 idle stays standby", int'(arr_en), 0);
        end
        chk(wcnt == '0, "R4 no window on steady inputs", int'(wcnt), 0);

        // Main function, several patterns
        wake(16'h1234);
        wake(16'hFFFF);
        wake(16'h0001);
        wake(16'h8000);

        // R4 hold after capture
        held = data_q;
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk(data_q == held && standby, "R4 data held in standby", int'(data_q), int'(held));
        chk(int'(wcnt) == exp_cnt, "R4 no extra window", int'(wcnt), exp_cnt);

        // R7 restart during window
        @(negedge clk);
        mon = 16'h0F0F;
        bump_cnt();
        repeat (3) @(negedge clk);
        chk(arr_en, "R7 window active before restart", int'(arr_en), 1);
        mon = 16'hA0A0;
        sb_q.push_back(model(16'hA0A0));
        n = 0;
        while (!stb && n < 40) begin @(negedge clk); n++; end
        chk(n == WIN + 2, "R7 restart latency", n, WIN + 2);
        @(negedge clk);
        chk(data_q == model(16'hA0A0), "R7 newest data", int'(data_q), int'(model(16'hA0A0)));
        chk(int'(wcnt) == exp_cnt, "R10 restart not counted", int'(wcnt), exp_cnt);

        // R5 chip-select override mid-window
        held = data_q;
        @(negedge clk);
        mon = 16'h5555;
        bump_cnt();
        repeat (2) @(negedge clk);
        chk(arr_en, "R5 window running", int'(arr_en), 1);
        cs = 1'b0;
        #1;
        chk(!arr_en && standby && !stb, "R5 immediate standby", int'(arr_en), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            mon = mon + 16'h0101;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (arr_en || stb || !standby) chk(1'b0, "R5 deselected activity", int'(arr_en), 0);
            end
        end
        chk(data_q == held, "R5 data unchanged while deselected", int'(data_q), int'(held));
        chk(int'(wcnt) == exp_cnt, "R5 no window while deselected", int'(wcnt), exp_cnt);

        // R8 reselect starts a refresh window
        @(negedge clk);
        cs = 1'b1;
        sb_q.push_back(model(mon));
        bump_cnt();
        n = 0;
        while (!stb && n < 40) begin @(negedge clk); n++; end
        chk(n == WIN + 1, "R8 reselect latency", n, WIN + 1);
        @(negedge clk);
        chk(data_q == model(mon), "R8 refreshed data", int'(data_q), int'(model(mon)));

        // R10 saturation
        for (int i = 0; i < 18; i++) wake(16'h2000 + 16'(i * 7 + 3));
        chk(int'(wcnt) == (1 << CNT_W) - 1, "R10 saturated count", int'(wcnt), (1 << CNT_W) - 1);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R2 all captures seen", sb_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule